// File: doc/BRIEF.md
# Rendezvous Channel Receive Controller

This block is the receiving side of an unbuffered, synchronous point-to-point channel. Neither side holds data for the other, so a value moves only in a cycle where both parties are willing. A one-cycle start pulse opens a receive. From that cycle on, the block advertises that it is ready, and it stays ready until the sender raises its own ready flag. In that rendezvous cycle the block raises a synch flag and loads the channel data into its result register. One clock later it emits a one-cycle finish pulse, which the surrounding control logic uses to start whatever comes next.

A receive is "active" in any cycle where the start pulse is present or a receive is already pending. The ready and synch outputs are combinational functions of that active term, so a sender that is already waiting completes the transfer with no wait cycles. The block also drives ready and synch flags for a parameterized number of channels it does not use, and holds them low, so that merging logic elsewhere sees those channels as silent.

Top module: `chan_recv_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the pending state and the finish pulse. With `CLEAR_DATA_ON_RESET=1` (the default) it also clears the received value to 0. After reset, with start low, `rcv_ready_o`, `synch_o` and `done_o` are 0.
- R2: `rcv_ready_o` is 1 in the same cycle that `start_i` is 1, with no register delay.
- R3: After a start, while `snd_ready_i` stays 0, the receive stays pending. `rcv_ready_o` remains 1 and `synch_o` remains 0 for any number of cycles.
- R4: `synch_o` is 1 exactly when a receive is active (start present or pending) and `snd_ready_i` is 1.
- R5: The received value loads `chan_data_i` at the clock edge that ends a synch cycle. At every other edge it holds, whatever `chan_data_i` does.
- R6: `done_o` is 1 in the cycle after a synch cycle and 0 in the cycle after that, unless a new synch occurred.
- R7: If `snd_ready_i` is already 1 in the start cycle, `synch_o` is 1 in that cycle and `done_o` is 1 in the next one, with no wait cycles.
- R8: After a rendezvous the pending state is cleared, so `rcv_ready_o` is 0 in the following cycle unless `start_i` is 1 again.
- R9: Every bit of `idle_ready_o` and `idle_synch_o` (flags of unused channels) is 0 at all times.
- R10: While no receive is active, a high `snd_ready_i` causes no synch, no finish pulse and no change of the received value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that opens a receive |
| snd_ready_i | input | 1 | Sender is willing to transfer this cycle |
| chan_data_i | input | DATA_W | Value offered by the sender |
| rcv_ready_o | output | 1 | Receiver is willing to transfer this cycle |
| synch_o | output | 1 | Rendezvous takes place this cycle |
| done_o | output | 1 | One-cycle finish pulse, one clock after the rendezvous |
| rx_data_o | output | DATA_W | Last received value |
| idle_ready_o | output | NUM_IDLE_CH | Ready flags of unused channels, held at 0 |
| idle_synch_o | output | NUM_IDLE_CH | Synch flags of unused channels, held at 0 |

## Verification
The bench checks the zero-wait case where the sender is already ready in the start cycle. A design that registered the ready or synch term would lose that cycle and report finish one clock late. It holds the sender off for several cycles to show that the pending state survives. A design that forgot pending would drop `rcv_ready_o` after the start pulse and never finish. It drives `snd_ready_i` high with no receive open and changes the channel data outside synch cycles. A design that gated the load with sender-ready alone would overwrite the result and emit a spurious finish. It also applies reset in the middle of a pending receive, which must leave the block idle and not stuck advertising readiness.

// File: rtl/chan_recv_pkg.sv
package chan_recv_pkg;

   // Per-cycle control terms shared between the pending stage and its consumers.
   typedef struct packed {
      logic active;   // start present or a receive still pending
      logic fire;     // rendezvous: active and sender ready
   } rdv_ctrl_t;

   localparam int unsigned MAX_DATA_W = 1024;

endpackage

// File: rtl/chan_recv_pend.sv
module chan_recv_pend
   import chan_recv_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      start_i,
   input  logic      peer_rdy_i,
   output rdv_ctrl_t ctrl_o
);

   logic pend_q;
   logic active;
   logic pend_d;

   assign active = start_i | pend_q;
   assign pend_d = active & ~peer_rdy_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
      end
   end

   assign ctrl_o.active = active;
   assign ctrl_o.fire   = active & peer_rdy_i;

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ctrl_o.active && !peer_rdy_i) |=> ctrl_o.active); // R3

   AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
      ctrl_o.fire |=> (ctrl_o.active == start_i)); // R8

endmodule

// File: rtl/chan_recv_capture.sv
module chan_recv_capture #(
   parameter int unsigned DATA_W              = 8,
   parameter bit          CLEAR_DATA_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);

   logic [DATA_W-1:0] data_q;

   if (CLEAR_DATA_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
         if (rst) begin
            data_q <= '0;
         end else if (load_i) begin
            data_q <= din_i;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (load_i) begin
            data_q <= din_i;
         end
      end
   end

   assign dout_o = data_q;

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (dout_o == $past(din_i))); // R5

   AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(dout_o)); // R5

endmodule

// File: rtl/chan_recv_done.sv
module chan_recv_done (
   input  logic clk,
   input  logic rst,
   input  logic fire_i,
   output logic done_o
);

   logic done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q <= 1'b0;
      end else begin
         done_q <= fire_i;
      end
   end

   assign done_o = done_q;

   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      fire_i |=> done_o); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (done_o && !fire_i) |=> !done_o); // R6

endmodule

// File: rtl/chan_recv_ctrl.sv
module chan_recv_ctrl
   import chan_recv_pkg::*;
#(
   parameter int unsigned DATA_W              = 8,
   parameter int unsigned NUM_IDLE_CH         = 2,
   parameter bit          CLEAR_DATA_ON_RESET = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start_i,
   input  logic                   snd_ready_i,
   input  logic [DATA_W-1:0]      chan_data_i,
   output logic                   rcv_ready_o,
   output logic                   synch_o,
   output logic                   done_o,
   output logic [DATA_W-1:0]      rx_data_o,
   output logic [NUM_IDLE_CH-1:0] idle_ready_o,
   output logic [NUM_IDLE_CH-1:0] idle_synch_o
);

   localparam int unsigned IDLE_LAST = NUM_IDLE_CH - 1;

   if (DATA_W < 1 || DATA_W > MAX_DATA_W) begin : g_bad_width
      $error("chan_recv_ctrl: DATA_W out of range");
   end
   if (NUM_IDLE_CH < 1) begin : g_bad_idle
      $error("chan_recv_ctrl: NUM_IDLE_CH must be at least 1");
   end

   rdv_ctrl_t ctrl;

   chan_recv_pend u_pend (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .peer_rdy_i (snd_ready_i),
      .ctrl_o     (ctrl)
   );

   chan_recv_capture #(
      .DATA_W              (DATA_W),
      .CLEAR_DATA_ON_RESET (CLEAR_DATA_ON_RESET)
   ) u_capture (
      .clk    (clk),
      .rst    (rst),
      .load_i (ctrl.fire),
      .din_i  (chan_data_i),
      .dout_o (rx_data_o)
   );

   chan_recv_done u_done (
      .clk    (clk),
      .rst    (rst),
      .fire_i (ctrl.fire),
      .done_o (done_o)
   );

   assign rcv_ready_o = ctrl.active;
   assign synch_o     = ctrl.fire;

   for (genvar ch = 0; ch <= IDLE_LAST; ch++) begin : g_idle
      assign idle_ready_o[ch] = 1'b0;
      assign idle_synch_o[ch] = 1'b0;
   end

   AST_START_ADVERTISES: assert property (@(posedge clk) disable iff (rst)
      start_i |-> rcv_ready_o); // R2

   AST_SYNCH_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
      synch_o |-> (rcv_ready_o && snd_ready_i)); // R4

   AST_IDLE_SENDER_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!rcv_ready_o && snd_ready_i) |=> (!done_o && $stable(rx_data_o))); // R10

endmodule

// File: tb/chan_recv_ctrl_tb.sv
module chan_recv_ctrl_tb;

   localparam int unsigned DW = 8;
   localparam int unsigned NI = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic          start_i;
   logic          snd_ready_i;
   logic [DW-1:0] chan_data_i;
   logic          rcv_ready_o;
   logic          synch_o;
   logic          done_o;
   logic [DW-1:0] rx_data_o;
   logic [NI-1:0] idle_ready_o;
   logic [NI-1:0] idle_synch_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   chan_recv_ctrl #(.DATA_W(DW), .NUM_IDLE_CH(NI)) u_dut (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .snd_ready_i  (snd_ready_i),
      .chan_data_i  (chan_data_i),
      .rcv_ready_o  (rcv_ready_o),
      .synch_o      (synch_o),
      .done_o       (done_o),
      .rx_data_o    (rx_data_o),
      .idle_ready_o (idle_ready_o),
      .idle_synch_o (idle_synch_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_val(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, req, what, act, exp);
   endtask

   // Inputs change on the falling edge; outputs are sampled 1 ns later.
   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk_idle_flags();
      #1;
      chk_val("R9", "idle_ready_o", 32'(idle_ready_o), 32'd0);
      chk_val("R9", "idle_synch_o", 32'(idle_synch_o), 32'd0);
   endtask

   task automatic t_reset();
      rst = 1'b1; start_i = 1'b0; snd_ready_i = 1'b0; chan_data_i = 8'h5A;
      repeat (3) step();
      rst = 1'b0;
      #1;
      chk_val("R1", "rcv_ready_o after reset", 32'(rcv_ready_o), 32'd0);
      chk_val("R1", "synch_o after reset", 32'(synch_o), 32'd0);
      chk_val("R1", "done_o after reset", 32'(done_o), 32'd0);
      chk_val("R1", "rx_data_o after reset", 32'(rx_data_o), 32'd0);
      chk_idle_flags();
   endtask

   task automatic t_wait(input int n, input logic [DW-1:0] d);
      logic [DW-1:0] old;
      step();
      old = rx_data_o;
      start_i = 1'b1; snd_ready_i = 1'b0; chan_data_i = ~d;
      #1;
      chk_val("R2", "rcv_ready_o in start cycle", 32'(rcv_ready_o), 32'd1);
      chk_val("R4", "synch_o without sender", 32'(synch_o), 32'd0);
      step();
      start_i = 1'b0;
      for (int i = 0; i < n; i++) begin
         chan_data_i = DW'(i * 37 + 3);
         #1;
         chk_val("R3", "rcv_ready_o while pending", 32'(rcv_ready_o), 32'd1);
         chk_val("R3", "synch_o while pending", 32'(synch_o), 32'd0);
         chk_val("R5", "rx_data_o held while pending", 32'(rx_data_o), 32'(old));
         chk_val("R6", "done_o while pending", 32'(done_o), 32'd0);
         step();
      end
      snd_ready_i = 1'b1; chan_data_i = d;
      #1;
      chk_val("R4", "synch_o at rendezvous", 32'(synch_o), 32'd1);
      chk_val("R5", "rx_data_o before capture edge", 32'(rx_data_o), 32'(old));
      step();
      snd_ready_i = 1'b0; chan_data_i = ~d;
      #1;
      chk_val("R6", "done_o after rendezvous", 32'(done_o), 32'd1);
      chk_val("R5", "rx_data_o captured", 32'(rx_data_o), 32'(d));
      chk_val("R8", "rcv_ready_o after rendezvous", 32'(rcv_ready_o), 32'd0);
      step();
      chan_data_i = d ^ 8'h0F;
      #1;
      chk_val("R6", "done_o second cycle", 32'(done_o), 32'd0);
      chk_val("R5", "rx_data_o holds", 32'(rx_data_o), 32'(d));
      chk_idle_flags();
   endtask

   task automatic t_zero_wait(input logic [DW-1:0] d);
      step();
      start_i = 1'b1; snd_ready_i = 1'b1; chan_data_i = d;
      #1;
      chk_val("R7", "synch_o in start cycle", 32'(synch_o), 32'd1);
      chk_val("R7", "rcv_ready_o in start cycle", 32'(rcv_ready_o), 32'd1);
      step();
      start_i = 1'b0; snd_ready_i = 1'b0; chan_data_i = ~d;
      #1;
      chk_val("R7", "done_o next cycle", 32'(done_o), 32'd1);
      chk_val("R7", "rx_data_o next cycle", 32'(rx_data_o), 32'(d));
      chk_val("R8", "rcv_ready_o cleared", 32'(rcv_ready_o), 32'd0);
      step();
      #1;
      chk_val("R6", "done_o drops", 32'(done_o), 32'd0);
   endtask

   task automatic t_idle_sender();
      logic [DW-1:0] old;
      step();
      old = rx_data_o;
      snd_ready_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         chan_data_i = DW'(8'hC0 + i);
         #1;
         chk_val("R10", "synch_o with no receive", 32'(synch_o), 32'd0);
         chk_val("R10", "rcv_ready_o with no receive", 32'(rcv_ready_o), 32'd0);
         chk_val("R10", "done_o with no receive", 32'(done_o), 32'd0);
         chk_val("R10", "rx_data_o untouched", 32'(rx_data_o), 32'(old));
         step();
      end
      snd_ready_i = 1'b0;
      #1;
      chk_val("R10", "done_o after idle sender", 32'(done_o), 32'd0);
      chk_val("R10", "rx_data_o after idle sender", 32'(rx_data_o), 32'(old));
   endtask

   task automatic t_reset_while_pending();
      step();
      start_i = 1'b1; snd_ready_i = 1'b0;
      step();
      start_i = 1'b0;
      step();
      rst = 1'b1;
      step();
      rst = 1'b0;
      #1;
      chk_val("R1", "rcv_ready_o after mid-receive reset", 32'(rcv_ready_o), 32'd0);
      chk_val("R1", "done_o after mid-receive reset", 32'(done_o), 32'd0);
      chk_val("R1", "rx_data_o after mid-receive reset", 32'(rx_data_o), 32'd0);
      step();
      snd_ready_i = 1'b1;
      #1;
      chk_val("R4", "synch_o after reset with sender", 32'(synch_o), 32'd0);
      step();
      snd_ready_i = 1'b0;
      #1;
      chk_val("R10", "done_o after reset with sender", 32'(done_o), 32'd0);
   endtask

   bit finished = 1'b0;

   initial begin
      t_reset();
      t_wait(0, 8'hA5);
      t_wait(5, 8'h3C);
      t_zero_wait(8'h81);
      t_idle_sender();
      t_wait(17, 8'hFF);
      t_zero_wait(8'h00);
      t_reset_while_pending();
      t_zero_wait(8'h7E);
      chk_idle_flags();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule